// File: doc/BRIEF.md
# DDC Random-Address Read Sequencer

This block runs a whole display-data-channel read as a single request. It sits above a batch two-wire command engine. That engine carries out one bus operation per command: a START, a STOP, a write of up to eight bytes, or a read of up to eight bytes. A request gives a 7-bit device address, an 8-bit or 16-bit word address, a byte count and, optionally, a segment index for the higher blocks of an extended display identification table. The sequencer then issues the following commands in order:

- the segment-pointer write, when a segment index is requested;
- the word-address write;
- a repeated START;
- the read-address byte;
- the data reads, split into chunks.

It checks the exact acknowledge pattern that the engine reports after every phase.

Received bytes leave the block one per clock on a strobed byte port, in ascending address order. At the end of a request a single-cycle done pulse carries the number of bytes delivered and an error flag. After any failure the sequencer still closes the bus with a STOP. Bus timing belongs to the engine. Writing to the target is not part of this block.

Top module: `ddc_rd_seq`

## Requirements
- R1: A request with a zero count, or one made while `eng_busy` is high, is refused. No engine command is issued, and the cycle after the request shows `done` with `done_count` 0 and `done_err` 1. A request made while `seq_busy` is high is ignored.
- R2: When `req_seg_en` is set, the first START is followed by a two-byte write of 0x60 then `req_seg`, and then another START. The expected acknowledge mask for that write is exactly 0x03.
- R3: In random-address mode the address write is [dev<<1, addr low] with expected mask 0x03 when `req_wide`=0. It is [dev<<1, addr high, addr low] with expected mask 0x07 when `req_wide`=1. A START follows the address write.
- R4: The read-address phase is a single-byte write of (dev<<1)|1 and requires mask exactly 0x01.
- R5: Data is read in chunks. Every chunk except the last uses read-with-ACK (op 2) and has 8 bytes. The last chunk uses read-with-NACK (op 3) and has 1 to 8 bytes. The number of ACK chunks is (count-1)/8.
- R6: A read chunk is accepted when the run of consecutive 1s in `eng_ack`, counted from bit 0, equals the chunk length for an ACK chunk or the chunk length minus one for the last chunk. Any other run aborts the request with `done_err`=1. Any write-phase mask mismatch also aborts with `done_err`=1.
- R7: Every request that issued commands ends with a STOP command. `done` rises only after that STOP completes, and `done_count` equals the number of bytes delivered.
- R8: In random-address mode the count is clamped to 256-addr[7:0] for 8-bit addresses and to 65536-addr for 16-bit addresses.
- R9: When `req_cur` is set, the word-address write and its START are skipped, and the count is not clamped.
- R10: The bytes of an accepted chunk leave the block on consecutive clocks with `rd_valid` high, byte k taken from `eng_rdata[8k+7:8k]`. No byte of a rejected chunk is delivered.
- R11: Engine interface and reset state. `cmd_op` codes are 0 START, 1 WRITE, 2 read-with-ACK, 3 read-with-NACK and 4 STOP. `cmd_len` holds the byte count minus one. Byte k of `cmd_wdata[8k+7:8k]` goes on the bus k-th, and `eng_ack` bit k is set when byte k was acknowledged. Only one command is outstanding until `eng_done`. After reset, `seq_busy`, `cmd_valid`, `rd_valid` and `done` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Request strobe, taken when idle |
| req_dev | input | 7 | Target device address |
| req_addr | input | 16 | Start word address |
| req_wide | input | 1 | 1: 16-bit word address, 0: 8-bit |
| req_cur | input | 1 | 1: read from the target's current address |
| req_seg_en | input | 1 | Insert the segment-pointer write |
| req_seg | input | 8 | Segment index |
| req_count | input | CNT_W | Requested byte count |
| seq_busy | output | 1 | Request in progress |
| cmd_valid | output | 1 | Command strobe to the engine |
| cmd_op | output | 3 | Command code |
| cmd_len | output | clog2(CHUNK) | Bytes minus one |
| cmd_wdata | output | 8*CHUNK | Write bytes, byte 0 first |
| eng_busy | input | 1 | Engine busy |
| eng_done | input | 1 | Command completed |
| eng_ack | input | CHUNK | Per-byte acknowledge |
| eng_rdata | input | 8*CHUNK | Read bytes, byte 0 first |
| rd_valid | output | 1 | Read byte strobe |
| rd_data | output | 8 | Read byte |
| done | output | 1 | Request finished (one cycle) |
| done_count | output | CNT_W | Bytes delivered |
| done_err | output | 1 | Refused or aborted |

## Verification
The bench builds the block with CNT_W=9 and CHUNK=8. A count of 9 bits lets a 256-byte read starting at address 0 run through all 32 chunks. It also lets counts above the clamp limit reach both the 8-bit and the 16-bit top-of-space boundaries. With a chunk of 8 bytes, the single-byte NACK tail after a full ACK chunk can be reached, as can a final chunk of exactly 8 bytes. A behavioural engine injects acknowledge faults into every phase, including an over-acknowledged final chunk.

// File: rtl/ddc_seq_pkg.sv
package ddc_seq_pkg;
  typedef enum logic [2:0] {
    OP_START   = 3'd0,
    OP_WRITE   = 3'd1,
    OP_RD_ACK  = 3'd2,
    OP_RD_NACK = 3'd3,
    OP_STOP    = 3'd4
  } eng_op_e;

  typedef enum logic [3:0] {
    S_IDLE, S_START, S_SEGW, S_ADRW, S_DEVR, S_READ, S_STREAM, S_STOP, S_FIN
  } seq_state_e;

  localparam logic [7:0] SEG_PTR_BYTE = 8'h60;
endpackage

// File: rtl/ddc_req_clamp.sv
module ddc_req_clamp #(
  parameter int CNT_W = 9
) (
  input  logic [CNT_W-1:0] count_i,
  input  logic [15:0]      addr_i,
  input  logic             wide_i,
  input  logic             cur_i,
  output logic [CNT_W-1:0] count_o
);
  localparam int LIM_W = (CNT_W > 17) ? CNT_W : 17;

  logic [LIM_W-1:0] limit, cnt_ext;

  always_comb begin
    cnt_ext = LIM_W'(count_i);
    if (wide_i) limit = LIM_W'(17'h10000) - LIM_W'(addr_i);
    else        limit = LIM_W'(17'h00100) - LIM_W'(addr_i[7:0]);
    if (cur_i || (cnt_ext <= limit)) count_o = count_i;
    else                             count_o = CNT_W'(limit);
  end
endmodule

// File: rtl/ddc_ack_eval.sv
module ddc_ack_eval #(
  parameter int CHUNK = 8,
  parameter int LEN_W = $clog2(CHUNK + 1)
) (
  input  logic [CHUNK-1:0] ack_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic             final_i,
  output logic             ok_o
);
  logic [CHUNK-1:0] run;
  logic [LEN_W-1:0] run_cnt;

  // run[i] is set while every bit from 0 to i was acknowledged
  genvar gi;
  generate
    for (gi = 0; gi < CHUNK; gi++) begin : g_run
      if (gi == 0) begin : g_first
        assign run[gi] = ack_i[gi];
      end else begin : g_next
        assign run[gi] = run[gi-1] & ack_i[gi];
      end
    end
  endgenerate

  always_comb begin
    run_cnt = LEN_W'($countones(run));
    if (final_i) ok_o = (run_cnt == len_i - LEN_W'(1));
    else         ok_o = (run_cnt == len_i);
  end
endmodule

// File: rtl/ddc_chunk_stream.sv
module ddc_chunk_stream #(
  parameter int CHUNK = 8,
  parameter int LEN_W = $clog2(CHUNK + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load_i,
  input  logic [8*CHUNK-1:0] data_i,
  input  logic [LEN_W-1:0]   len_i,
  output logic               valid_o,
  output logic [7:0]         byte_o,
  output logic               last_o
);
  logic [8*CHUNK-1:0] buf_q, buf_d;
  logic [LEN_W-1:0]   left_q, left_d;
  logic               buf_en;

  assign valid_o = (left_q != '0);
  assign last_o  = (left_q == LEN_W'(1));
  assign byte_o  = buf_q[7:0];
  assign buf_en  = load_i | valid_o;

  always_comb begin
    buf_d  = buf_q;
    left_d = left_q;
    if (load_i) begin
      buf_d  = data_i;
      left_d = len_i;
    end else if (valid_o) begin
      buf_d  = buf_q >> 8;
      left_d = left_q - LEN_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      left_q <= '0;
    end else begin
      left_q <= left_d;
    end
  end

  always_ff @(posedge clk) begin
    if (buf_en) buf_q <= buf_d;
  end
endmodule

// File: rtl/ddc_rd_seq.sv
module ddc_rd_seq
  import ddc_seq_pkg::*;
#(
  parameter int CNT_W = 9,
  parameter int CHUNK = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       req_valid,
  input  logic [6:0]                 req_dev,
  input  logic [15:0]                req_addr,
  input  logic                       req_wide,
  input  logic                       req_cur,
  input  logic                       req_seg_en,
  input  logic [7:0]                 req_seg,
  input  logic [CNT_W-1:0]           req_count,
  output logic                       seq_busy,
  output logic                       cmd_valid,
  output logic [2:0]                 cmd_op,
  output logic [$clog2(CHUNK)-1:0]   cmd_len,
  output logic [8*CHUNK-1:0]         cmd_wdata,
  input  logic                       eng_busy,
  input  logic                       eng_done,
  input  logic [CHUNK-1:0]           eng_ack,
  input  logic [8*CHUNK-1:0]         eng_rdata,
  output logic                       rd_valid,
  output logic [7:0]                 rd_data,
  output logic                       done,
  output logic [CNT_W-1:0]           done_count,
  output logic                       done_err
);
  localparam int LEN_W = $clog2(CHUNK + 1);
  localparam int OPL_W = $clog2(CHUNK);

  // reset: asserted asynchronously, released after two clocks
  logic [1:0] rsync_q;
  logic       arst_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign arst_n = rsync_q[1];

  seq_state_e       state_q, state_d;
  logic             wait_q, wait_d;
  logic             seg_pend_q, seg_pend_d, adr_pend_q, adr_pend_d, err_q, err_d;
  logic [CNT_W-1:0] remain_q, remain_d, sent_q, sent_d, clamped;
  logic [6:0]       dev_q;
  logic [15:0]      addr_q;
  logic             wide_q;
  logic [7:0]       seg_q;
  logic             accept, final_chunk, rd_ok, wr_ok, strm_load, strm_last, in_cmd;
  logic [LEN_W-1:0] chunk_len, wr_nbytes;
  eng_op_e          op_sel;

  function automatic logic [CHUNK-1:0] low_mask(input logic [LEN_W-1:0] n);
    low_mask = '0;
    for (int i = 0; i < CHUNK; i++) if (i < int'(n)) low_mask[i] = 1'b1;
  endfunction

  ddc_req_clamp #(.CNT_W(CNT_W)) u_clamp (
    .count_i(req_count), .addr_i(req_addr), .wide_i(req_wide),
    .cur_i(req_cur), .count_o(clamped));

  assign final_chunk = (remain_q <= CNT_W'(CHUNK));
  assign chunk_len   = final_chunk ? remain_q[LEN_W-1:0] : LEN_W'(CHUNK);

  ddc_ack_eval #(.CHUNK(CHUNK), .LEN_W(LEN_W)) u_eval (
    .ack_i(eng_ack), .len_i(chunk_len), .final_i(final_chunk), .ok_o(rd_ok));

  ddc_chunk_stream #(.CHUNK(CHUNK), .LEN_W(LEN_W)) u_strm (
    .clk(clk), .rst_n(arst_n), .load_i(strm_load), .data_i(eng_rdata),
    .len_i(chunk_len), .valid_o(rd_valid), .byte_o(rd_data), .last_o(strm_last));

  assign accept = (state_q == S_IDLE) && req_valid && (req_count != '0) && !eng_busy;

  // command fields decoded from the phase
  always_comb begin
    in_cmd    = 1'b1;
    op_sel    = OP_START;
    wr_nbytes = LEN_W'(1);
    cmd_wdata = '0;
    unique case (state_q)
      S_START: op_sel = OP_START;
      S_SEGW: begin
        op_sel          = OP_WRITE;
        wr_nbytes       = LEN_W'(2);
        cmd_wdata[7:0]  = SEG_PTR_BYTE;
        cmd_wdata[15:8] = seg_q;
      end
      S_ADRW: begin
        op_sel         = OP_WRITE;
        cmd_wdata[7:0] = {dev_q, 1'b0};
        if (wide_q) begin
          wr_nbytes        = LEN_W'(3);
          cmd_wdata[15:8]  = addr_q[15:8];
          cmd_wdata[23:16] = addr_q[7:0];
        end else begin
          wr_nbytes       = LEN_W'(2);
          cmd_wdata[15:8] = addr_q[7:0];
        end
      end
      S_DEVR: begin
        op_sel         = OP_WRITE;
        cmd_wdata[7:0] = {dev_q, 1'b1};
      end
      S_READ:  op_sel = final_chunk ? OP_RD_NACK : OP_RD_ACK;
      S_STOP:  op_sel = OP_STOP;
      default: in_cmd = 1'b0;
    endcase
  end

  assign wr_ok     = (eng_ack == low_mask(wr_nbytes));
  assign cmd_valid = in_cmd && !wait_q;
  assign cmd_op    = op_sel;
  assign cmd_len   = (state_q == S_READ) ? OPL_W'(chunk_len - LEN_W'(1))
                                         : OPL_W'(wr_nbytes - LEN_W'(1));

  // next-state logic
  always_comb begin
    state_d    = state_q;
    wait_d     = wait_q;
    seg_pend_d = seg_pend_q;
    adr_pend_d = adr_pend_q;
    err_d      = err_q;
    remain_d   = remain_q;
    sent_d     = rd_valid ? sent_q + CNT_W'(1) : sent_q;
    strm_load  = 1'b0;
    if (cmd_valid) begin
      wait_d = 1'b1;
    end else if (wait_q && eng_done) begin
      wait_d = 1'b0;
      unique case (state_q)
        S_START: state_d = seg_pend_q ? S_SEGW : (adr_pend_q ? S_ADRW : S_DEVR);
        S_SEGW:  begin seg_pend_d = !wr_ok; state_d = wr_ok ? S_START : S_STOP; end
        S_ADRW:  begin adr_pend_d = !wr_ok; state_d = wr_ok ? S_START : S_STOP; end
        S_DEVR:  state_d = wr_ok ? S_READ : S_STOP;
        S_READ:  begin strm_load = rd_ok; state_d = rd_ok ? S_STREAM : S_STOP; end
        default: state_d = S_FIN;
      endcase
      if (((state_q == S_SEGW) || (state_q == S_ADRW) || (state_q == S_DEVR)) && !wr_ok)
        err_d = 1'b1;
      if ((state_q == S_READ) && !rd_ok) err_d = 1'b1;
    end
    unique case (state_q)
      S_IDLE: if (req_valid) begin
        sent_d     = '0;
        err_d      = !accept;
        remain_d   = clamped;
        seg_pend_d = req_seg_en;
        adr_pend_d = !req_cur;
        state_d    = accept ? S_START : S_FIN;
      end
      S_STREAM: if (strm_last) begin
        remain_d = remain_q - CNT_W'(chunk_len);
        state_d  = final_chunk ? S_STOP : S_READ;
      end
      S_FIN:   state_d = S_IDLE;
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      state_q    <= S_IDLE;
      wait_q     <= 1'b0;
      seg_pend_q <= 1'b0;
      adr_pend_q <= 1'b0;
      err_q      <= 1'b0;
      remain_q   <= '0;
      sent_q     <= '0;
    end else begin
      state_q    <= state_d;
      wait_q     <= wait_d;
      seg_pend_q <= seg_pend_d;
      adr_pend_q <= adr_pend_d;
      err_q      <= err_d;
      remain_q   <= remain_d;
      sent_q     <= sent_d;
    end
  end

  always_ff @(posedge clk) begin
    if (accept) begin
      dev_q  <= req_dev;
      addr_q <= req_addr;
      wide_q <= req_wide;
      seg_q  <= req_seg;
    end
  end

  assign seq_busy   = (state_q != S_IDLE);
  assign done       = (state_q == S_FIN);
  assign done_count = sent_q;
  assign done_err   = err_q;
endmodule

// File: rtl/ddc_rd_seq_chk.sv
module ddc_rd_seq_chk
  import ddc_seq_pkg::*;
#(
  parameter int CNT_W = 9,
  parameter int CHUNK = 8
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     req_valid,
  input logic [CNT_W-1:0]         req_count,
  input logic                     seq_busy,
  input logic                     cmd_valid,
  input logic [2:0]               cmd_op,
  input logic [$clog2(CHUNK)-1:0] cmd_len,
  input logic                     eng_done,
  input logic                     rd_valid,
  input logic                     done,
  input logic [CNT_W-1:0]         done_count,
  input logic                     done_err
);
  localparam int OPL_W = $clog2(CHUNK);
  localparam logic [OPL_W-1:0] FULL_LEN = OPL_W'(CHUNK - 1);

  logic             out_q, stop_last_q;
  logic [CNT_W-1:0] beats_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q       <= 1'b0;
      stop_last_q <= 1'b1;
      beats_q     <= '0;
    end else begin
      if (cmd_valid)     out_q <= 1'b1;
      else if (eng_done) out_q <= 1'b0;
      if (cmd_valid) stop_last_q <= (cmd_op == 3'd4);
      if (done)          beats_q <= '0;
      else if (rd_valid) beats_q <= beats_q + CNT_W'(1);
    end
  end

  AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> !out_q); // R11
  AST_NO_CMD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !seq_busy |-> !cmd_valid); // R11
  AST_REFUSE_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !seq_busy && (req_count == '0)) |=> (done && (done_count == '0) && done_err)); // R1
  AST_STOP_BEFORE_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> stop_last_q); // R7
  AST_ACK_CHUNK_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && (cmd_op == 3'd2)) |-> (cmd_len == FULL_LEN)); // R5
  AST_COUNT_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (done_count == beats_q)); // R10
endmodule

bind ddc_rd_seq ddc_rd_seq_chk #(.CNT_W(CNT_W), .CHUNK(CHUNK)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_count(req_count),
  .seq_busy(seq_busy), .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_len(cmd_len),
  .eng_done(eng_done), .rd_valid(rd_valid), .done(done), .done_count(done_count),
  .done_err(done_err));

// File: tb/sim_ddc_rd_seq.sv
module sim_ddc_rd_seq;
  localparam int CNT_W = 9;
  localparam int CHUNK = 8;
  localparam logic [6:0] DEV = 7'h50;
  localparam int OP_START = 0, OP_WRITE = 1, OP_RACK = 2, OP_RNACK = 3, OP_STOP = 4;

  logic clk, rst_n;
  logic req_valid, req_wide, req_cur, req_seg_en;
  logic [6:0] req_dev;
  logic [15:0] req_addr;
  logic [7:0] req_seg;
  logic [CNT_W-1:0] req_count;
  logic seq_busy, cmd_valid, rd_valid, done, done_err;
  logic [2:0] cmd_op, cmd_len;
  logic [63:0] cmd_wdata, eng_rdata;
  logic eng_busy, eng_busy_m, busy_force, eng_done;
  logic [7:0] eng_ack, rd_data;
  logic [CNT_W-1:0] done_count;

  assign eng_busy = eng_busy_m | busy_force;

  ddc_rd_seq #(.CNT_W(CNT_W), .CHUNK(CHUNK)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_dev(req_dev),
    .req_addr(req_addr), .req_wide(req_wide), .req_cur(req_cur),
    .req_seg_en(req_seg_en), .req_seg(req_seg), .req_count(req_count),
    .seq_busy(seq_busy), .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_len(cmd_len),
    .cmd_wdata(cmd_wdata), .eng_busy(eng_busy), .eng_done(eng_done),
    .eng_ack(eng_ack), .eng_rdata(eng_rdata), .rd_valid(rd_valid),
    .rd_data(rd_data), .done(done), .done_count(done_count), .done_err(done_err));

  initial begin clk = 1'b0; forever #5 clk = ~clk; end

  int checks = 0, fails = 0;
  int fault_abs = -1;

  // behavioural target model behind the engine
  logic [7:0]  m_seg;
  logic [15:0] m_ptr;
  int cmd_total = 0, log_n = 0;
  int log_op [0:4095];
  int log_len[0:4095];

  function automatic logic [7:0] mem_byte(input logic [7:0] s, input logic [15:0] a);
    return (a[7:0] * 8'd7) ^ a[15:8] ^ (s * 8'd29) ^ 8'h3C;
  endfunction

  function automatic logic [7:0] mask_of(input int n);
    logic [7:0] m = '0;
    for (int i = 0; i < 8; i++) if (i < n) m[i] = 1'b1;
    return m;
  endfunction

  initial begin
    logic [63:0] rd;
    logic [7:0]  ack;
    int op, ln;
    eng_done = 0; eng_busy_m = 0; eng_ack = '0; eng_rdata = '0; m_seg = '0; m_ptr = '0;
    forever begin
      @(negedge clk);
      eng_done = 0;
      if (cmd_valid) begin
        op = int'(cmd_op); ln = int'(cmd_len);
        if (log_n < 4096) begin log_op[log_n] = op; log_len[log_n] = ln; end
        log_n++;
        eng_busy_m = 1; ack = '0; rd = '0;
        if (op == OP_WRITE) begin
          if (cmd_wdata[7:0] == 8'h60 && ln == 1) begin
            m_seg = cmd_wdata[15:8]; ack = 8'h03;
          end else if (cmd_wdata[7:1] == DEV) begin
            if (!cmd_wdata[0]) begin
              if (ln == 1) m_ptr = {8'h00, cmd_wdata[15:8]};
              else if (ln == 2) m_ptr = {cmd_wdata[15:8], cmd_wdata[23:16]};
            end
            ack = mask_of(ln + 1);
          end
          if (cmd_total == fault_abs) ack[ln] = 1'b0;
        end else if (op == OP_RACK || op == OP_RNACK) begin
          for (int i = 0; i <= ln; i++) rd[8*i +: 8] = mem_byte(m_seg, m_ptr + 16'(i));
          m_ptr = m_ptr + 16'(ln + 1);
          ack = (op == OP_RACK) ? mask_of(ln + 1) : mask_of(ln);
          if (cmd_total == fault_abs) ack = (op == OP_RACK) ? 8'h00 : 8'hFF;
        end else if (op == OP_STOP) begin
          m_seg = '0;
        end
        cmd_total++;
        repeat (1 + $urandom % 3) @(negedge clk);
        eng_ack = ack; eng_rdata = rd; eng_done = 1; eng_busy_m = 0;
      end
    end
  end

  // byte capture
  int got_n = 0;
  logic [7:0] got_b[0:4095];
  int got_t[0:4095];
  initial begin
    int cyc = 0;
    forever begin
      @(negedge clk);
      cyc++;
      if (rd_valid && got_n < 4096) begin got_b[got_n] = rd_data; got_t[got_n] = cyc; got_n++; end
    end
  end

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    $display("FAIL watchdog expired act=hung exp=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks + 1, fails + 1);
    $finish;
  end

  task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s act=%0d exp=%0d", tag, what, act, exp);
    end
  endtask

  int exp_n;
  int exp_op [0:63];
  int exp_len[0:63];

  task automatic push(input int op, input int len);
    if (exp_n < 64) begin exp_op[exp_n] = op; exp_len[exp_n] = len; end
    exp_n++;
  endtask

  task automatic run_txn(input string tag, input bit seg_en, input logic [7:0] seg,
                         input bit wide, input bit cur, input logic [15:0] addr,
                         input int count, input int frel, input bit force_busy);
    int eff, lim, exp_cnt, rem, len, lbase, gbase, wd, bad, badi;
    bit exp_err, failed;
    logic [15:0] start;
    logic [7:0] sexp;
    lim = wide ? 65536 - int'(addr) : 256 - int'(addr[7:0]);
    eff = (cur || count <= lim) ? count : lim;
    start = cur ? m_ptr : (wide ? addr : {8'h00, addr[7:0]});
    sexp = seg_en ? seg : 8'h00;
    exp_n = 0; exp_cnt = 0; failed = 0;
    if (count == 0 || force_busy) begin
      failed = 1;
    end else begin
      push(OP_START, 0);
      if (seg_en) begin
        push(OP_WRITE, 1); if (exp_n - 1 == frel) failed = 1;
        if (!failed) push(OP_START, 0);
      end
      if (!failed && !cur) begin
        push(OP_WRITE, wide ? 2 : 1); if (exp_n - 1 == frel) failed = 1;
        if (!failed) push(OP_START, 0);
      end
      if (!failed) begin push(OP_WRITE, 0); if (exp_n - 1 == frel) failed = 1; end
      rem = eff;
      while (!failed && rem > 0) begin
        len = (rem > 8) ? 8 : rem;
        push((rem > 8) ? OP_RACK : OP_RNACK, len - 1);
        if (exp_n - 1 == frel) failed = 1;
        else begin exp_cnt += len; rem -= len; end
      end
      push(OP_STOP, 0);
    end
    exp_err = failed;
    lbase = log_n; gbase = got_n;
    fault_abs = (frel < 0) ? -1 : cmd_total + frel;
    busy_force = force_busy;
    @(negedge clk);
    req_valid = 1; req_dev = DEV; req_addr = addr; req_wide = wide; req_cur = cur;
    req_seg_en = seg_en; req_seg = seg; req_count = CNT_W'(count);
    @(negedge clk);
    req_valid = 0;
    wd = 0;
    while (!done && wd < 20000) begin @(negedge clk); wd++; end
    busy_force = 0;
    chk(done == 1'b1, tag, "done seen", int'(done), 1);
    chk(int'(done_count) == exp_cnt, tag, "done_count", int'(done_count), exp_cnt);
    chk(done_err == exp_err, tag, "done_err (R6)", int'(done_err), int'(exp_err));
    bad = 0; badi = -1;
    if (log_n - lbase != exp_n) bad = 1;
    else for (int i = 0; i < exp_n && i < 64; i++)
      if (log_op[lbase+i] != exp_op[i] || log_len[lbase+i] != exp_len[i]) begin
        if (!bad) badi = i; bad = 1;
      end
    chk(bad == 0, tag, "command sequence length/first bad index", log_n - lbase, badi < 0 ? exp_n : -badi);
    bad = (got_n - gbase != exp_cnt) ? 1 : 0; badi = -1;
    for (int i = 0; i < exp_cnt && bad == 0; i++) begin
      if (got_b[gbase+i] != mem_byte(sexp, start + 16'(i))) begin bad = 1; badi = i; end
      if (i % 8 != 0 && got_t[gbase+i] != got_t[gbase+i-1] + 1) begin bad = 1; badi = i; end
    end
    chk(bad == 0, tag, "R10 bytes delivered/first bad index", got_n - gbase, badi < 0 ? exp_cnt : -badi);
    @(negedge clk);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 0; req_valid = 0; req_dev = '0; req_addr = '0; req_wide = 0; req_cur = 0;
    req_seg_en = 0; req_seg = '0; req_count = '0; busy_force = 0;
    repeat (4) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    chk(!seq_busy && !cmd_valid && !rd_valid && !done, "R11", "reset state idle",
        int'({seq_busy, cmd_valid, rd_valid, done}), 0);

    run_txn("R1", 0, 8'h0, 0, 0, 16'h0010, 0, -1, 0);
    run_txn("R1", 0, 8'h0, 0, 0, 16'h0010, 5, -1, 1);
    run_txn("R5", 0, 8'h0, 0, 0, 16'h0010, 8, -1, 0);
    run_txn("R5", 0, 8'h0, 0, 0, 16'h0020, 9, -1, 0);
    run_txn("R2", 1, 8'h2, 0, 0, 16'h0080, 20, -1, 0);
    run_txn("R3", 0, 8'h0, 1, 0, 16'h1234, 17, -1, 0);
    run_txn("R8", 0, 8'h0, 1, 0, 16'hFFFC, 10, -1, 0);
    run_txn("R8", 0, 8'h0, 0, 0, 16'h00F0, 40, -1, 0);
    run_txn("R5", 0, 8'h0, 0, 0, 16'h0000, 256, -1, 0);
    run_txn("R9", 0, 8'h0, 0, 1, 16'h0000, 5, -1, 0);
    run_txn("R9", 1, 8'h1, 0, 1, 16'h0000, 11, -1, 0);
    run_txn("R2", 1, 8'h3, 0, 0, 16'h0004, 6, 1, 0);
    run_txn("R7", 0, 8'h0, 0, 0, 16'h0004, 6, 1, 0);
    run_txn("R3", 0, 8'h0, 1, 0, 16'h0104, 6, 1, 0);
    run_txn("R4", 0, 8'h0, 0, 0, 16'h0004, 6, 3, 0);
    run_txn("R6", 0, 8'h0, 0, 0, 16'h0004, 20, 5, 0);
    run_txn("R6", 0, 8'h0, 0, 0, 16'h0004, 3, 4, 0);

    for (int t = 0; t < 30; t++) begin
      bit s_en, w, c;
      logic [15:0] a;
      int n, f;
      s_en = ($urandom % 3) == 0;
      w = $urandom % 2;
      c = ($urandom % 5) == 0;
      a = w ? 16'($urandom) : 16'($urandom % 256);
      if ($urandom % 4 == 0) a = w ? 16'hFFFF - 16'($urandom % 20) : 16'h00FF - 16'($urandom % 20);
      n = 1 + $urandom % 40;
      f = ($urandom % 4 == 0) ? int'($urandom % 12) : -1;
      run_txn("R5", s_en, 8'($urandom % 4), w, c, a, n, f, 0);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule